// File: doc/BRIEF.md
# Serial Port Byte Queues with Trigger, Timeout and DMA Ready Pins

This block sits between the shift registers of an asynchronous serial port and the host bus. It holds two byte queues. The receive queue stores incoming characters together with three error bits. The transmit queue holds bytes that the host has written. Around the queues it produces the host-visible status: a data-present flag, a receive request that follows a programmable fill threshold, and a sticky overrun flag. It also drives two active-low handshake pins for a DMA engine.

A single enable selects between queue operation and a one-deep holding register for each direction. A receive timeout covers characters left below the threshold. The timeout lasts four character times, counted in half-bit ticks, so the 1.5-stop-bit format is exact. The shift registers, baud divider, register decoding and interrupt priority logic lie outside the block. They reach it only through strobes and configuration fields.

Data moves through three valid/ready streams. The host write stream is back-pressured by `tx_wr_ready`. The serial transmitter pulls bytes with `tx_out_ready`. The host takes receive data with `rx_rd_ready`. The receive shifter cannot be held off: `rx_in_valid` has no ready, and a character that finds the queue full is dropped and recorded as an overrun.

Top module: `uart_queue_core`

## Requirements
- R1: While reset is held and after its release, both queues are empty, `rx_rd_valid`, `tx_out_valid`, `rx_trig_req`, `rx_timeout` and `rx_overrun` are 0, `rxrdy_n` is 1, `txrdy_n` is 0 and `tx_wr_ready` is 1.
- R2: With `fifo_en`=1 each queue holds DEPTH (16) entries and returns them in arrival order. With `fifo_en`=0 each queue holds exactly one entry. A write offered while the transmit queue is full is not stored.
- R3: `trig_sel` values 0, 1, 2 and 3 select fill thresholds of 1, 4, 8 and 14 characters. `rx_trig_req` is 1 exactly while the stored receive count is at or above the threshold. With `fifo_en`=0 the threshold is 1 regardless of `trig_sel`.
- R4: `rx_rd_valid` is 1 from the cycle after the first character is stored until the queue becomes empty. Characters keep being stored after the threshold is reached, up to full capacity.
- R5: The timeout limit is 4 × H half-bit ticks, where H = 2·(1 + data bits + parity bit) + stop halves. Data bits are 5 + `char_bits`. Stop halves are 2, 3 or 4 for `stop_sel` 0, 1 or 2 (3 behaves as 2). The counter restarts on every `rx_in_valid`, every accepted host read and every receive flush. `rx_timeout` is 1 once the limit is reached while the queue is non-empty, and it is never 1 while the queue is empty.
- R6: In DMA mode 0 (`dma_mode`=0, or `fifo_en`=0), `rxrdy_n` is 0 exactly while at least one receive character is held. `txrdy_n` is 0 exactly while the transmit path is empty.
- R7: In DMA mode 1 (`fifo_en`=1, `dma_mode`=1), `rxrdy_n` falls when the count reaches the threshold or a timeout occurs, and it rises only when the receive queue is empty. `txrdy_n` is 1 only while the transmit queue is completely full.
- R8: A one-cycle `rx_flush` or `tx_flush` empties the corresponding queue and its counters. It leaves `rx_overrun` untouched.
- R9: A character that arrives while the receive queue is full is discarded and sets `rx_overrun`. The flag stays set until `lsr_read` is pulsed.
- R10: A transfer occurs on a stream only in a cycle where both valid and ready are 1. `tx_out_data` and `rx_rd_data`/`rx_rd_err` show the oldest entry while their valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: DEPTH-entry queues, 0: one-entry holding registers |
| trig_sel | input | 2 | Receive threshold select (1/4/8/14) |
| dma_mode | input | 1 | Ready-pin mode select (0 or 1) |
| char_bits | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present in the character |
| stop_sel | input | 2 | Stop length: 0 = 1 bit, 1 = 1.5 bits, 2/3 = 2 bits |
| half_bit_tick | input | 1 | One pulse per half bit time |
| rx_flush | input | 1 | Empty the receive queue (pulse) |
| tx_flush | input | 1 | Empty the transmit queue (pulse) |
| rx_in_valid | input | 1 | Received character strobe, at the stop-bit centre |
| rx_in_data | input | 8 | Received character |
| rx_in_err | input | 3 | Error bits stored with the character |
| rx_rd_valid | output | 1 | Receive data present (data-ready status) |
| rx_rd_ready | input | 1 | Host read of the receive head |
| rx_rd_data | output | 8 | Oldest received character |
| rx_rd_err | output | 3 | Error bits of the oldest character |
| rx_trig_req | output | 1 | Receive threshold request |
| rx_timeout | output | 1 | Receive timeout flag |
| rx_overrun | output | 1 | Sticky overrun flag |
| lsr_read | input | 1 | Line status read, clears the overrun flag |
| tx_wr_valid | input | 1 | Host write strobe |
| tx_wr_data | input | 8 | Host write byte |
| tx_wr_ready | output | 1 | Transmit queue has room |
| tx_out_valid | output | 1 | Byte available for the transmitter |
| tx_out_data | output | 8 | Oldest transmit byte |
| tx_out_ready | input | 1 | Transmitter takes the byte |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| txrdy_n | output | 1 | Active-low transmit DMA request |

## Verification
The hardest state to reach from the ports is a mode-1 receive request held low by a timeout alone. This needs a queue that stays below a high threshold, with exactly the limit of half-bit ticks and no restart in between. The stimulus sets threshold 14 and stores a single character. It then pulses the tick input exactly 4·H − 1 times and one more time, and it does this for three character formats whose limits the bench computes from the formula. Restarts are tested by inserting a new character, or a host read, one tick before expiry, and the pin is checked to stay low until the last character is read.

// File: rtl/uart_q_pkg.sv
package uart_q_pkg;

  localparam int unsigned ERR_W = 3;
  // Widest limit: 4 * (2*(1+8+1) + 4) = 96 half bits
  localparam int unsigned TMO_W = 7;

  typedef struct packed {
    logic [ERR_W-1:0] err;
    logic [7:0]       data;
  } rx_ent_t;

  // Fill threshold scaled to the queue depth: 1, D/4, D/2, D-2
  function automatic int unsigned trig_of(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // Length of one character in half-bit units
  function automatic int unsigned char_halves(input logic [1:0] cb, input logic par,
                                              input logic [1:0] stp);
    int unsigned stop_h;
    stop_h = (stp == 2'd0) ? 2 : (stp == 2'd1) ? 3 : 4;
    return 2 * (6 + int'(cb) + int'(par)) + stop_h;
  endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         single,
  input  logic                         push_valid,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push_valid && !full;
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer
  import uart_q_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic       holding,
  input  logic [1:0] char_bits,
  input  logic       parity_en,
  input  logic [1:0] stop_sel,
  output logic       expired
);
  logic [TMO_W-1:0] limit, cnt;

  assign limit   = TMO_W'(4 * char_halves(char_bits, parity_en, stop_sel));
  assign expired = holding && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart || !holding) cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/dma_ready_pins.sv
module dma_ready_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic block_mode,
  input  logic rx_nonempty,
  input  logic rx_reached,
  input  logic rx_expired,
  input  logic tx_empty,
  input  logic tx_full,
  output logic rxrdy_n,
  output logic txrdy_n
);
  logic armed_q, rx_active;

  // Block mode: request holds once started until the queue drains
  assign rx_active = rx_nonempty && (armed_q || rx_reached || rx_expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= block_mode && rx_active;
  end

  assign rxrdy_n = block_mode ? !rx_active : !rx_nonempty;
  assign txrdy_n = block_mode ? tx_full    : !tx_empty;

endmodule

// File: rtl/uart_queue_core.sv
module uart_queue_core
  import uart_q_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic [1:0] trig_sel,
  input  logic       dma_mode,
  input  logic [1:0] char_bits,
  input  logic       parity_en,
  input  logic [1:0] stop_sel,
  input  logic       half_bit_tick,
  input  logic       rx_flush,
  input  logic       tx_flush,
  input  logic       rx_in_valid,
  input  logic [7:0] rx_in_data,
  input  logic [2:0] rx_in_err,
  output logic       rx_rd_valid,
  input  logic       rx_rd_ready,
  output logic [7:0] rx_rd_data,
  output logic [2:0] rx_rd_err,
  output logic       rx_trig_req,
  output logic       rx_timeout,
  output logic       rx_overrun,
  input  logic       lsr_read,
  input  logic       tx_wr_valid,
  input  logic [7:0] tx_wr_data,
  output logic       tx_wr_ready,
  output logic       tx_out_valid,
  output logic [7:0] tx_out_data,
  input  logic       tx_out_ready,
  output logic       rxrdy_n,
  output logic       txrdy_n
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  rx_ent_t       rx_in_ent, rx_head;
  logic [CW-1:0] rx_cnt, tx_cnt, trig_lvl;
  logic          rx_full, tx_full;

  assign rx_in_ent = '{err: rx_in_err, data: rx_in_data};

  byte_queue #(.W($bits(rx_ent_t)), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n,
    .flush(rx_flush), .single(!fifo_en),
    .push_valid(rx_in_valid), .push_data(rx_in_ent),
    .pop(rx_rd_ready), .head(rx_head),
    .count(rx_cnt), .full(rx_full)
  );

  byte_queue #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n,
    .flush(tx_flush), .single(!fifo_en),
    .push_valid(tx_wr_valid), .push_data(tx_wr_data),
    .pop(tx_out_ready), .head(tx_out_data),
    .count(tx_cnt), .full(tx_full)
  );

  assign rx_rd_valid  = (rx_cnt != '0);
  assign rx_rd_data   = rx_head.data;
  assign rx_rd_err    = rx_head.err;
  assign tx_wr_ready  = !tx_full;
  assign tx_out_valid = (tx_cnt != '0);

  // R3: threshold is 1 when the queues are bypassed
  assign trig_lvl    = fifo_en ? CW'(trig_of(trig_sel, DEPTH)) : CW'(1);
  assign rx_trig_req = (rx_cnt >= trig_lvl);

  // R5: restarts at each stop-bit centre, host read or flush
  rx_char_timer u_tmo (
    .clk, .rst_n,
    .tick(half_bit_tick),
    .restart(rx_in_valid || (rx_rd_valid && rx_rd_ready) || rx_flush),
    .holding(rx_rd_valid),
    .char_bits, .parity_en, .stop_sel,
    .expired(rx_timeout)
  );

  // R9: sticky overrun, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rx_overrun <= 1'b0;
    else if (rx_in_valid && rx_full) rx_overrun <= 1'b1;
    else if (lsr_read)              rx_overrun <= 1'b0;
  end

  dma_ready_pins u_dma (
    .clk, .rst_n,
    .block_mode(fifo_en && dma_mode),
    .rx_nonempty(rx_rd_valid),
    .rx_reached(rx_trig_req),
    .rx_expired(rx_timeout),
    .tx_empty(!tx_out_valid),
    .tx_full(tx_full),
    .rxrdy_n, .txrdy_n
  );

endmodule

// File: rtl/uart_queue_core_chk.sv
module uart_queue_core_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_flush,
  input logic                       tx_flush,
  input logic                       rx_in_valid,
  input logic                       rx_full,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic                       rx_rd_valid,
  input logic                       rx_rd_ready,
  input logic                       rx_timeout,
  input logic                       rx_overrun,
  input logic                       lsr_read,
  input logic                       tx_wr_valid,
  input logic                       tx_wr_ready,
  input logic                       tx_out_valid
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  a_r4_ready_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_full && !rx_flush) |=> rx_rd_valid);

  a_r5_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rd_valid |-> !rx_timeout);

  a_r5_read_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_valid && rx_rd_ready) |=> !rx_timeout);

  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_full) |=> rx_overrun);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !lsr_read) |=> rx_overrun);

  a_r10_tx_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_valid && tx_wr_ready && !tx_flush) |=> tx_out_valid);

endmodule

bind uart_queue_core uart_queue_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_flush(rx_flush), .tx_flush(tx_flush),
  .rx_in_valid(rx_in_valid), .rx_full(rx_full), .rx_cnt(rx_cnt),
  .rx_rd_valid(rx_rd_valid), .rx_rd_ready(rx_rd_ready),
  .rx_timeout(rx_timeout), .rx_overrun(rx_overrun), .lsr_read(lsr_read),
  .tx_wr_valid(tx_wr_valid), .tx_wr_ready(tx_wr_ready),
  .tx_out_valid(tx_out_valid)
);

// File: tb/uart_queue_core_test.sv
module uart_queue_core_test;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, dma_mode = 1'b0, parity_en = 1'b0, half_bit_tick = 1'b0;
  logic [1:0] trig_sel = '0, char_bits = 2'd3, stop_sel = '0;
  logic rx_flush = 1'b0, tx_flush = 1'b0, rx_in_valid = 1'b0, rx_rd_ready = 1'b0;
  logic [7:0] rx_in_data = '0, tx_wr_data = '0;
  logic [2:0] rx_in_err = '0;
  logic lsr_read = 1'b0, tx_wr_valid = 1'b0, tx_out_ready = 1'b0;
  logic rx_rd_valid, rx_trig_req, rx_timeout, rx_overrun, tx_wr_ready, tx_out_valid;
  logic rxrdy_n, txrdy_n;
  logic [7:0] rx_rd_data, tx_out_data;
  logic [2:0] rx_rd_err;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  uart_queue_core #(.DEPTH(DEPTH)) uut (.*);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rx_push(input logic [7:0] d, input logic [2:0] e);
    rx_in_valid = 1'b1; rx_in_data = d; rx_in_err = e;
    step();
    rx_in_valid = 1'b0;
  endtask

  task automatic rx_pop();
    rx_rd_ready = 1'b1; step(); rx_rd_ready = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin half_bit_tick = 1'b1; step(); end
    half_bit_tick = 1'b0;
  endtask

  task automatic flush_all();
    rx_flush = 1'b1; tx_flush = 1'b1; lsr_read = 1'b1; step();
    rx_flush = 1'b0; tx_flush = 1'b0; lsr_read = 1'b0;
  endtask

  function automatic int lvl_of(input int ts);
    return (ts == 0) ? 1 : (ts == 1) ? 4 : (ts == 2) ? 8 : 14;
  endfunction

  initial begin
    repeat (3) step();
    check("R1 rxrdy_n in reset", rxrdy_n, 1);
    check("R1 txrdy_n in reset", txrdy_n, 0);
    rst_n = 1'b1;
    step();
    check("R1 rx_rd_valid", rx_rd_valid, 0);
    check("R1 tx_out_valid", tx_out_valid, 0);
    check("R1 trig/timeout/overrun", {rx_trig_req, rx_timeout, rx_overrun}, 0);
    check("R1 tx_wr_ready", tx_wr_ready, 1);

    // Receive sweep over both ready-pin modes and all thresholds
    fifo_en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int ts = 0; ts < 4; ts++) begin
        int lvl;
        dma_mode = m[0]; trig_sel = ts[1:0]; lvl = lvl_of(ts);
        flush_all();
        for (int i = 0; i < DEPTH; i++) begin
          int n;
          rx_push(8'(i*7 + ts), 3'(i));
          n = i + 1;
          check("R3 trig req on fill", rx_trig_req, int'(n >= lvl));
          check("R4 data ready on fill", rx_rd_valid, 1);
          check(m == 0 ? "R6 rxrdy_n fill" : "R7 rxrdy_n fill", rxrdy_n,
                m == 0 ? 0 : int'(n < lvl));
        end
        check("R9 no overrun before full", rx_overrun, 0);
        rx_push(8'hEE, 3'd7);
        check("R9 overrun on full", rx_overrun, 1);
        step();
        check("R9 overrun sticky", rx_overrun, 1);
        for (int i = 0; i < DEPTH; i++) begin
          int n;
          check("R2 rx order data", rx_rd_data, (i*7 + ts) & 255);
          check("R10 rx err bits", rx_rd_err, i % 8);
          rx_pop();
          n = DEPTH - 1 - i;
          check("R3 trig req on drain", rx_trig_req, int'(n >= lvl));
          check("R4 data ready on drain", rx_rd_valid, int'(n > 0));
          check(m == 0 ? "R6 rxrdy_n drain" : "R7 rxrdy_n drain", rxrdy_n, int'(n == 0));
        end
        check("R9 overrun until status read", rx_overrun, 1);
        lsr_read = 1'b1; step(); lsr_read = 1'b0;
        check("R9 overrun cleared", rx_overrun, 0);
      end
    end

    // Transmit sweep over both modes
    for (int m = 0; m < 2; m++) begin
      dma_mode = m[0];
      flush_all();
      check(m == 0 ? "R6 txrdy_n empty" : "R7 txrdy_n empty", txrdy_n, 0);
      for (int i = 0; i < DEPTH; i++) begin
        check("R2 tx room", tx_wr_ready, 1);
        tx_wr_valid = 1'b1; tx_wr_data = 8'(8'hA0 + i + m); step();
        tx_wr_valid = 1'b0;
        check("R10 tx out valid", tx_out_valid, 1);
        check(m == 0 ? "R6 txrdy_n fill" : "R7 txrdy_n fill", txrdy_n,
              m == 0 ? 1 : int'(i + 1 == DEPTH));
      end
      check("R2 tx full", tx_wr_ready, 0);
      tx_wr_valid = 1'b1; tx_wr_data = 8'h55; step(); tx_wr_valid = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        check("R2 tx order data", tx_out_data, (8'hA0 + i + m) & 255);
        tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
        check(m == 0 ? "R6 txrdy_n drain" : "R7 txrdy_n drain", txrdy_n,
              m == 0 ? int'(i + 1 < DEPTH) : 0);
      end
      check("R2 write while full dropped", tx_out_valid, 0);
    end

    // Holding-register operation, mode-1 setting must be ignored
    fifo_en = 1'b0; dma_mode = 1'b1; trig_sel = 2'd3;
    flush_all();
    rx_push(8'h41, 3'd2);
    check("R3 threshold 1 when bypassed", rx_trig_req, 1);
    check("R6 rxrdy_n bypassed", rxrdy_n, 0);
    rx_push(8'h42, 3'd0);
    check("R9 overrun at depth one", rx_overrun, 1);
    check("R2 holding keeps first", rx_rd_data, 8'h41);
    rx_pop();
    check("R2 holding empty", rx_rd_valid, 0);
    check("R6 rxrdy_n bypassed empty", rxrdy_n, 1);
    tx_wr_valid = 1'b1; tx_wr_data = 8'h61; step();
    check("R2 tx holding full", tx_wr_ready, 0);
    check("R6 txrdy_n bypassed", txrdy_n, 1);
    tx_wr_data = 8'h62; step(); tx_wr_valid = 1'b0;
    check("R2 tx holding data", tx_out_data, 8'h61);
    tx_out_ready = 1'b1; step(); tx_out_ready = 1'b0;
    check("R2 second write dropped", tx_out_valid, 0);

    // Timeout for three character formats
    fifo_en = 1'b1; dma_mode = 1'b1; trig_sel = 2'd3;
    for (int f = 0; f < 3; f++) begin
      int h, lim;
      char_bits = (f == 0) ? 2'd3 : (f == 1) ? 2'd0 : 2'd2;
      parity_en = (f == 2);
      stop_sel  = (f == 0) ? 2'd0 : (f == 1) ? 2'd1 : 2'd2;
      h = 2 * (1 + 5 + int'(char_bits) + int'(parity_en)) + ((f == 0) ? 2 : (f == 1) ? 3 : 4);
      lim = 4 * h;
      flush_all();
      ticks(lim + 5);
      check("R5 no timeout when empty", rx_timeout, 0);
      rx_push(8'h10, 3'd0);
      ticks(lim - 1);
      check("R5 not yet expired", rx_timeout, 0);
      check("R7 rxrdy_n below threshold", rxrdy_n, 1);
      ticks(1);
      check("R5 expired at limit", rx_timeout, 1);
      check("R7 rxrdy_n on timeout", rxrdy_n, 0);
      rx_push(8'h11, 3'd0);
      check("R5 new char restarts", rx_timeout, 0);
      check("R7 rxrdy_n holds", rxrdy_n, 0);
      ticks(lim - 1);
      check("R5 restarted count", rx_timeout, 0);
      rx_pop();
      ticks(lim - 1);
      check("R5 read restarts", rx_timeout, 0);
      ticks(1);
      check("R5 expired after read", rx_timeout, 1);
      rx_pop();
      check("R5 cleared when empty", rx_timeout, 0);
      check("R7 rxrdy_n released when empty", rxrdy_n, 1);
    end

    // Flush pulses
    dma_mode = 1'b0; trig_sel = 2'd0;
    flush_all();
    for (int i = 0; i < 5; i++) rx_push(8'(i), 3'd0);
    for (int i = 0; i < 3; i++) begin
      tx_wr_valid = 1'b1; tx_wr_data = 8'(i); step();
    end
    tx_wr_valid = 1'b0;
    lsr_read = 1'b0;
    for (int i = 0; i < DEPTH; i++) rx_push(8'hFF, 3'd0);
    check("R9 overrun before flush", rx_overrun, 1);
    rx_flush = 1'b1; tx_flush = 1'b1; step(); rx_flush = 1'b0; tx_flush = 1'b0;
    check("R8 rx emptied", rx_rd_valid, 0);
    check("R8 tx emptied", tx_out_valid, 0);
    check("R8 pins after flush", {rxrdy_n, txrdy_n}, 2'b10);
    check("R8 overrun kept", rx_overrun, 1);
    rx_push(8'h77, 3'd5);
    check("R8 fresh head after flush", rx_rd_data, 8'h77);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule